// File: doc/BRIEF.md
# Integrating Converter Result Latch with Byte Handshake Port

This block sits behind the counter of an integrating analog-to-digital converter. When a conversion finishes it captures the count together with a sign bit and an over-range bit. It also keeps a conversion-status flag. The flag goes high when the input-integrate phase starts and goes low half a clock after a new result has been stored. The stored result therefore never moves while the flag is low, so a host can treat the low level as "data valid".

A host reads the stored result in one of two ways. In direct mode it asserts a chip enable together with one byte enable and gets that byte on an 8-bit bus. In handshake mode the block pushes the bytes one at a time to an external serial transmitter. It raises a load strobe for each byte and waits for a send acknowledge before it moves on. A single high pulse on the mode input sends one burst and then falls back to direct mode. Holding the mode input high sends a fresh burst after every conversion. The count width is a parameter, 14 or 16 bits. The 16-bit build uses three bytes and the 14-bit build uses two.

Top module: `adc_result_port`

## Requirements
- R1: After reset, `status_out`, `load_strobe` and `bus_drive` are all low.
- R2: A high `integ_start` sampled on a rising clock edge drives `status_out` high at the next falling edge.
- R3: A high `result_ready` sampled while `status_out` is high and no burst is running stores count, sign and over-range. `status_out` then drops at the following falling edge.
- R4: A high `result_ready` sampled while `status_out` is low is ignored. The stored result and `status_out` keep their values.
- R5: In the 16-bit build, `chip_en` with `lo_en` reads count[7:0], with `mid_en` reads count[15:8], and with `hi_en` reads {sign, over-range, 6'b0}, with sign in bit 7. If several byte enables are high, the lowest byte wins. `bus_drive` is high while such a read is active.
- R6: With `chip_en` low and no handshake byte presented, `bus_drive` is low whatever the byte enables are.
- R7: A mode pulse of one cycle sends the stored result once, byte 0 first and the top byte last (3 bytes in the 16-bit build, 2 in the 14-bit build). After that, conversions with the mode input low send nothing.
- R8: While the mode input stays high, every stored conversion is followed by a burst that carries the new result.
- R9: Each handshake byte stays on `bus_out`, with `load_strobe` high and `bus_drive` high, until `send_ack` is sampled high. `load_strobe` is then low for at least one cycle before the next byte.
- R10: A `result_ready` that arrives during a burst is dropped. The stored result keeps its earlier value, and `status_out` stays high.
- R11: In the 14-bit build the high byte is {sign, over-range, count[13:8]}, with sign in bit 7, and `mid_en` alone drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_in | input | CNT_W | Conversion count |
| sign_in | input | 1 | Polarity of the conversion |
| ovr_in | input | 1 | Over-range flag of the conversion |
| integ_start | input | 1 | Strobe: input-integrate phase begins |
| result_ready | input | 1 | Strobe: conversion result is valid |
| mode_in | input | 1 | Low = direct reads, pulse = one burst, held high = burst per conversion |
| chip_en | input | 1 | Direct-read chip enable |
| lo_en | input | 1 | Direct-read enable, low byte |
| mid_en | input | 1 | Direct-read enable, middle byte (16-bit build only) |
| hi_en | input | 1 | Direct-read enable, high byte |
| send_ack | input | 1 | Transmitter has taken the presented byte |
| load_strobe | output | 1 | A handshake byte is presented |
| bus_out | output | 8 | Output byte |
| bus_drive | output | 1 | Output enable for the byte bus |
| status_out | output | 1 | Conversion in progress; low means stored data is stable |

## Verification
The scoreboard sees three mode patterns. A single mode pulse must give exactly one burst and nothing on the conversion that follows. A held mode level must give one burst per conversion, each with new data. A conversion that lands during a burst must leave the old bytes in place. Count values with the high and low bytes set to distinct patterns, and different sign/over-range pairs, expose swapped or misplaced byte lanes. The bench holds back each acknowledge by one cycle to show the byte is held. Direct reads with several enables at once, with the chip enable low, and on the 14-bit build show the lane priority and the gating.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LOAD = 2'd1,
      SQ_GAP  = 2'd2
   } seq_state_t;

   // number of bytes needed for a given count width
   function automatic int byte_count(input int cnt_w);
      return (cnt_w > 14) ? 3 : 2;
   endfunction

   function automatic int idx_width(input int nb);
      return (nb > 2) ? 2 : 1;
   endfunction

endpackage

// File: rtl/adc_status_flag.sv
// Status flag registered on the falling clock edge: set by the
// start-of-integrate marker, cleared by the stored-result marker.
module adc_status_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end

endmodule

// File: rtl/adc_byte_map.sv
// Splits the stored word into host bytes; the layout depends on count width.
module adc_byte_map #(
   parameter int CNT_W = 16,
   parameter int NB    = 3
) (
   input  logic [CNT_W-1:0]    cnt_i,
   input  logic                sign_i,
   input  logic                ovr_i,
   output logic [NB-1:0][7:0]  bytes_o
);

   generate
      if (CNT_W == 16 && NB == 3) begin : g_w16
         always_comb begin
            bytes_o[0] = cnt_i[7:0];
            bytes_o[1] = cnt_i[15:8];
            bytes_o[2] = {sign_i, ovr_i, 6'b000000};
         end
      end else if (CNT_W == 14 && NB == 2) begin : g_w14
         always_comb begin
            bytes_o[0] = cnt_i[7:0];
            bytes_o[1] = {sign_i, ovr_i, cnt_i[13:8]};
         end
      end else begin : g_bad
         $error("adc_byte_map: CNT_W must be 14 or 16 with matching NB");
         assign bytes_o = '0;
      end
   endgenerate

endmodule

// File: rtl/adc_burst_seq.sv
// Steps through the bytes of one burst under the load / acknowledge handshake.
module adc_burst_seq
   import adc_port_pkg::*;
#(
   parameter int NB = 3,
   localparam int IW = idx_width(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic          ack_i,
   output logic          busy_o,
   output logic          load_o,
   output logic [IW-1:0] idx_o
);

   localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

   seq_state_t state_q;
   logic [IW-1:0] idx_q;

   initial begin
      if (NB < 2 || NB > 3) $error("adc_burst_seq: NB must be 2 or 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               idx_q <= '0;
               if (go_i) state_q <= SQ_LOAD;
            end
            SQ_LOAD: begin
               if (ack_i) begin
                  if (idx_q == LAST_IDX) state_q <= SQ_IDLE;
                  else                   state_q <= SQ_GAP;
               end
            end
            SQ_GAP: begin
               idx_q   <= idx_q + 1'b1;
               state_q <= SQ_LOAD;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != SQ_IDLE);
   assign load_o = (state_q == SQ_LOAD);
   assign idx_o  = idx_q;

endmodule

// File: rtl/adc_read_mux.sv
// Chooses the byte for the output bus: the handshake byte during a burst,
// otherwise the byte selected by the direct-read enables (lowest wins).
module adc_read_mux
   import adc_port_pkg::*;
#(
   parameter int NB = 3,
   localparam int IW = idx_width(NB)
) (
   input  logic [NB-1:0][7:0] bytes_i,
   input  logic               busy_i,
   input  logic               load_i,
   input  logic [IW-1:0]      idx_i,
   input  logic               chip_en_i,
   input  logic               lo_en_i,
   input  logic               mid_en_i,
   input  logic               hi_en_i,
   output logic [7:0]         bus_o,
   output logic               drive_o
);

   logic mid_sel;

   generate
      if (NB == 3) begin : g_mid
         assign mid_sel = mid_en_i;
      end else begin : g_nomid
         assign mid_sel = 1'b0;
      end
   endgenerate

   always_comb begin
      bus_o   = 8'h00;
      drive_o = 1'b0;
      if (load_i) begin
         bus_o   = bytes_i[idx_i];
         drive_o = 1'b1;
      end else if (!busy_i && chip_en_i) begin
         if (lo_en_i) begin
            bus_o   = bytes_i[0];
            drive_o = 1'b1;
         end else if (mid_sel) begin
            bus_o   = bytes_i[1];
            drive_o = 1'b1;
         end else if (hi_en_i) begin
            bus_o   = bytes_i[NB-1];
            drive_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
   import adc_port_pkg::*;
#(
   parameter int CNT_W = 16,
   localparam int NB   = byte_count(CNT_W),
   localparam int IW   = idx_width(NB),
   localparam int WW   = CNT_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_in,
   input  logic             sign_in,
   input  logic             ovr_in,
   input  logic             integ_start,
   input  logic             result_ready,
   input  logic             mode_in,
   input  logic             chip_en,
   input  logic             lo_en,
   input  logic             mid_en,
   input  logic             hi_en,
   input  logic             send_ack,
   output logic             load_strobe,
   output logic [7:0]       bus_out,
   output logic             bus_drive,
   output logic             status_out
);

   initial begin
      if (CNT_W != 14 && CNT_W != 16) $error("adc_result_port: CNT_W must be 14 or 16");
   end

   logic [WW-1:0]      lat_q;      // {sign, over-range, count}
   logic               start_seen;
   logic               wr_seen;
   logic               mode_q;
   logic               busy;
   logic               store_en;
   logic               burst_go;
   logic [IW-1:0]      idx;
   logic [NB-1:0][7:0] bytes;

   assign store_en = result_ready & status_out & ~busy;
   assign burst_go = mode_in & (~mode_q | wr_seen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q      <= '0;
         start_seen <= 1'b0;
         wr_seen    <= 1'b0;
         mode_q     <= 1'b0;
      end else begin
         start_seen <= integ_start;
         wr_seen    <= store_en;
         mode_q     <= mode_in;
         if (store_en) lat_q <= {sign_in, ovr_in, count_in};
      end
   end

   adc_status_flag i_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (start_seen),
      .clr_i  (wr_seen),
      .flag_o (status_out)
   );

   adc_byte_map #(.CNT_W(CNT_W), .NB(NB)) i_map (
      .cnt_i   (lat_q[CNT_W-1:0]),
      .sign_i  (lat_q[WW-1]),
      .ovr_i   (lat_q[WW-2]),
      .bytes_o (bytes)
   );

   adc_burst_seq #(.NB(NB)) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (burst_go),
      .ack_i  (send_ack),
      .busy_o (busy),
      .load_o (load_strobe),
      .idx_o  (idx)
   );

   adc_read_mux #(.NB(NB)) i_mux (
      .bytes_i   (bytes),
      .busy_i    (busy),
      .load_i    (load_strobe),
      .idx_i     (idx),
      .chip_en_i (chip_en),
      .lo_en_i   (lo_en),
      .mid_en_i  (mid_en),
      .hi_en_i   (hi_en),
      .bus_o     (bus_out),
      .drive_o   (bus_drive)
   );

endmodule

// File: rtl/adc_result_port_chk.sv
module adc_result_port_chk #(
   parameter int W = 18
) (
   input logic         clk,
   input logic         rst_n,
   input logic         integ_start,
   input logic         result_ready,
   input logic         chip_en,
   input logic         send_ack,
   input logic         load_strobe,
   input logic [7:0]   bus_out,
   input logic         bus_drive,
   input logic         status_out,
   input logic [W-1:0] lat_q
);

   // R2: integrate start raises the status flag by the next edge
   assert_status_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      integ_start |=> status_out);

   // R3: stored data only moves while the status flag is high
   assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !status_out |=> $stable(lat_q));

   // R6: bus not driven without chip enable outside a burst byte
   assert_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en && !load_strobe) |-> !bus_drive);

   // R9: presented byte held until acknowledged
   assert_byte_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_strobe && !send_ack) |=> (load_strobe && $stable(bus_out)));

   // R9: strobe drops after an acknowledge
   assert_gap_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_strobe && send_ack) |=> !load_strobe);

   // R10: a result arriving during a presented byte is not stored
   assert_drop_in_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load_strobe && result_ready) |=> $stable(lat_q));

endmodule

bind adc_result_port adc_result_port_chk #(.W(CNT_W + 2)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .integ_start  (integ_start),
   .result_ready (result_ready),
   .chip_en      (chip_en),
   .send_ack     (send_ack),
   .load_strobe  (load_strobe),
   .bus_out      (bus_out),
   .bus_drive    (bus_drive),
   .status_out   (status_out),
   .lat_q        (lat_q)
);

// File: tb/test_adc_result_port.sv
`timescale 1ns/1ps
module test_adc_result_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] count_in = '0;
   logic        sign_in = 1'b0, ovr_in = 1'b0;
   logic        integ_start = 1'b0, result_ready = 1'b0;
   logic        mode_in = 1'b0;
   logic        chip_en = 1'b0, lo_en = 1'b0, mid_en = 1'b0, hi_en = 1'b0;
   logic        send_ack = 1'b0;
   logic        load_strobe, bus_drive, status_out;
   logic [7:0]  bus_out;
   logic        load14, drive14, status14;
   logic [7:0]  bus14;

   int          n_tests = 0, n_fail = 0, n_loads = 0;
   bit          done = 0;
   logic [7:0]  exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;   // 250 MHz

   adc_result_port #(.CNT_W(16)) i_adc_result_port (
      .clk(clk), .rst_n(rst_n), .count_in(count_in), .sign_in(sign_in), .ovr_in(ovr_in),
      .integ_start(integ_start), .result_ready(result_ready), .mode_in(mode_in),
      .chip_en(chip_en), .lo_en(lo_en), .mid_en(mid_en), .hi_en(hi_en),
      .send_ack(send_ack), .load_strobe(load_strobe), .bus_out(bus_out),
      .bus_drive(bus_drive), .status_out(status_out));

   adc_result_port #(.CNT_W(14)) i_adc_result_port_14 (
      .clk(clk), .rst_n(rst_n), .count_in(count_in[13:0]), .sign_in(sign_in), .ovr_in(ovr_in),
      .integ_start(integ_start), .result_ready(result_ready), .mode_in(1'b0),
      .chip_en(chip_en), .lo_en(lo_en), .mid_en(mid_en), .hi_en(hi_en),
      .send_ack(1'b0), .load_strobe(load14), .bus_out(bus14),
      .bus_drive(drive14), .status_out(status14));

   function automatic logic [7:0] exp16(input int i, input logic [15:0] c, input logic p, input logic o);
      if (i == 0) return c[7:0];
      if (i == 1) return c[15:8];
      return {p, o, 6'b000000};
   endfunction

   function automatic logic [7:0] exp14(input int i, input logic [15:0] c, input logic p, input logic o);
      if (i == 0) return c[7:0];
      return {p, o, c[13:8]};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic sample();
      @(negedge clk); #1;
   endtask

   task automatic push16(input logic [15:0] c, input logic p, input logic o, input string tag);
      for (int i = 0; i < 3; i++) begin
         exp_q.push_back(exp16(i, c, p, o));
         tag_q.push_back(tag);
      end
   endtask

   // full conversion: integrate start, then a result
   task automatic conv(input logic [15:0] c, input logic p, input logic o, input bit burst);
      integ_start = 1'b1; tick(); integ_start = 1'b0;
      tick(); sample();
      chk(status_out == 1'b1, "R2 status rise", status_out, 1);
      tick();
      count_in = c; sign_in = p; ovr_in = o; result_ready = 1'b1;
      if (burst) push16(c, p, o, "R8 held-mode burst");
      tick(); result_ready = 1'b0;
      sample();
      chk(status_out == 1'b0, "R3 status fall", status_out, 0);
      tick();
   endtask

   // conversion while a burst is running
   task automatic conv_busy(input logic [15:0] c);
      integ_start = 1'b1; tick(); integ_start = 1'b0;
      tick();
      count_in = c; sign_in = 1'b1; ovr_in = 1'b1; result_ready = 1'b1;
      tick(); result_ready = 1'b0;
      sample();
      chk(status_out == 1'b1, "R10 status held", status_out, 1);
      tick();
   endtask

   task automatic rd(input logic ce, input logic l, input logic m, input logic h, input bit use14,
                     input logic exp_drv, input logic [7:0] exp_b, input string tag);
      chip_en = ce; lo_en = l; mid_en = m; hi_en = h;
      #0.5;
      if (use14) begin
         chk(drive14 == exp_drv, tag, drive14, exp_drv);
         if (exp_drv) chk(bus14 == exp_b, tag, bus14, exp_b);
      end else begin
         chk(bus_drive == exp_drv, tag, bus_drive, exp_drv);
         if (exp_drv) chk(bus_out == exp_b, tag, bus_out, exp_b);
      end
      chip_en = 1'b0; lo_en = 1'b0; mid_en = 1'b0; hi_en = 1'b0;
      #0.5;
   endtask

   task automatic drain();
      wait (exp_q.size() == 0);
      repeat (8) tick();
   endtask

   // monitor: compares each presented byte, holds one cycle, acknowledges
   initial begin
      forever begin
         sample();
         if (rst_n && load_strobe) begin
            logic [7:0] b0;
            n_loads++;
            b0 = bus_out;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected burst byte", b0, 0);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(b0 == e && bus_drive, t, b0, e);
            end
            tick(); sample();
            chk(load_strobe && bus_out == b0, "R9 byte held", bus_out, b0);
            tick(); send_ack = 1'b1;
            tick(); send_ack = 1'b0;
            sample();
            chk(load_strobe == 1'b0, "R9 gap after ack", load_strobe, 0);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int loads_before;
      repeat (3) tick();
      sample();
      chk(status_out == 1'b0, "R1 status reset", status_out, 0);
      chk(load_strobe == 1'b0, "R1 load reset", load_strobe, 0);
      chk(bus_drive == 1'b0, "R1 drive reset", bus_drive, 0);
      tick(); rst_n = 1'b1; tick();

      // direct mode conversion
      conv(16'hA5C3, 1'b1, 1'b0, 0);
      rd(1, 1, 0, 0, 0, 1, exp16(0, 16'hA5C3, 1, 0), "R5 low byte");
      rd(1, 0, 1, 0, 0, 1, exp16(1, 16'hA5C3, 1, 0), "R5 mid byte");
      rd(1, 0, 0, 1, 0, 1, exp16(2, 16'hA5C3, 1, 0), "R5 high byte");
      rd(1, 1, 0, 1, 0, 1, exp16(0, 16'hA5C3, 1, 0), "R5 priority");
      rd(0, 1, 1, 1, 0, 0, 8'h00, "R6 no chip enable");
      rd(1, 0, 0, 1, 1, 1, exp14(1, 16'hA5C3, 1, 0), "R11 14-bit high byte");
      rd(1, 1, 0, 0, 1, 1, exp14(0, 16'hA5C3, 1, 0), "R11 14-bit low byte");
      rd(1, 0, 1, 0, 1, 0, 8'h00, "R11 14-bit mid ignored");

      // R4: result while status low
      count_in = 16'h1234; result_ready = 1'b1; tick(); result_ready = 1'b0;
      sample();
      chk(status_out == 1'b0, "R4 status unchanged", status_out, 0);
      tick();
      rd(1, 1, 0, 0, 0, 1, 8'hC3, "R4 data unchanged");
      rd(1, 0, 1, 0, 0, 1, 8'hA5, "R4 data unchanged");

      // R7: single mode pulse
      push16(16'hA5C3, 1'b1, 1'b0, "R7 pulse burst");
      mode_in = 1'b1; tick(); mode_in = 1'b0;
      drain();
      chk(n_loads == 3, "R7 burst length", n_loads, 3);
      loads_before = n_loads;
      conv(16'h0F0F, 1'b0, 1'b1, 0);
      repeat (12) tick();
      chk(n_loads == loads_before, "R7 no burst after return", n_loads, loads_before);

      // R8: held mode
      push16(16'h0F0F, 1'b0, 1'b1, "R8 held-mode start");
      mode_in = 1'b1; tick();
      drain();
      conv(16'h8001, 1'b1, 1'b1, 1);
      drain();
      conv(16'h7FFE, 1'b0, 1'b0, 1);
      // R10: conversion during the burst is dropped
      conv_busy(16'hFFFF);
      drain();
      mode_in = 1'b0; tick();
      rd(1, 1, 0, 0, 0, 1, 8'hFE, "R10 old data kept");
      rd(1, 0, 0, 1, 0, 1, 8'h00, "R10 old data kept");
      chk(exp_q.size() == 0, "R8 all bytes seen", exp_q.size(), 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule